// File: doc/BRIEF.md
# Waveform Output Sequencer

This block paces the playback of a stored waveform toward a 12-bit DAC. A free-running timebase tick sets the time scale for the whole block. A rising edge on the trigger input starts a sequence from idle. The sequence first waits out a programmable start delay. It then plays a fixed number of points, spaced a programmable number of ticks apart. After each complete waveform it waits a programmable gap and begins the next iteration. It ends after the programmed number of iterations, or never ends if that count is zero.

For each output point the block presents a buffer read address together with a read strobe. One cycle later it pulses a DAC update strobe, which gives a single-cycle sample buffer time to return its data. A software abort stops playback in one of three ways, chosen by a stop-mode code:
- drop at once and request a zero-code clamp on the output;
- finish the waveform in progress;
- finish the whole iteration set.

Triggers that arrive while a sequence is active are ignored. When a sequence finishes, a re-trigger enable decides the next step. If it is set, the block returns to idle. If it is clear, the block stays in its finished state until an abort.

Top module: `wave_seq`

## Requirements
- R1: After reset, `busy`, `rd_en`, `dac_upd` and `zero_clamp` are low and `rd_addr` is 0.
- R2: A rising edge of `trig_in` seen in idle starts a sequence. The first read strobe comes on the (`start_dly`+2)th tick after the trigger is sampled. Each strobe is coincident with a tick.
- R3: Within one waveform, consecutive read strobes are `upd_ivl` ticks apart. A value of 0 is treated as 1.
- R4: `rd_addr` is 0 at the first strobe of every iteration, steps by one on each strobe, and reaches `npts`-1 at the last strobe of the waveform.
- R5: `dac_upd` pulses for one cycle exactly one cycle after each read strobe, and at no other time.
- R6: A sequence produces `npts`×`iter_cnt` strobes when `iter_cnt` is nonzero. It repeats without end when `iter_cnt` is 0.
- R7: The first strobe of the next iteration comes `gap_dly`+2 ticks after the last strobe of the previous one.
- R8: A trigger edge that arrives while `busy` is high has no effect on the strobe count or timing.
- R9: `busy` is high in every state except idle. With `retrig_en`=1, `busy` falls two cycles after the final strobe. With `retrig_en`=0, `busy` stays high and triggers are ignored until an abort returns the block to idle.
- R10: An abort with `stop_mode` 0 or 1 returns the block to idle on the next cycle. No further strobes follow. `zero_clamp` rises and stays high until the next accepted trigger.
- R11: An abort with `stop_mode` 2 lets the current waveform run to its `npts`th point, then stops.
- R12: An abort with `stop_mode` 3 lets all `iter_cnt` iterations complete. When `iter_cnt` is 0, it stops at the end of the current iteration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Timebase tick, one-cycle pulse |
| trig_in | input | 1 | Trigger; rising edge starts a sequence |
| retrig_en | input | 1 | Return to idle after completion |
| abort | input | 1 | Software stop request, one-cycle pulse |
| stop_mode | input | 2 | 0/1 immediate, 2 end of waveform, 3 end of iteration set |
| upd_ivl | input | CNT_W | Ticks between output points |
| npts | input | ADDR_W+1 | Points per waveform, at least 1 |
| iter_cnt | input | CNT_W | Iterations; 0 means endless |
| start_dly | input | CNT_W | Delay after trigger, in ticks |
| gap_dly | input | CNT_W | Delay between iterations, in ticks |
| rd_addr | output | ADDR_W | Sample buffer read address |
| rd_en | output | 1 | Sample buffer read strobe |
| dac_upd | output | 1 | DAC update strobe |
| zero_clamp | output | 1 | Request to hold the DAC at zero code |
| busy | output | 1 | Sequence active |

## Verification
The properties assume that the configuration inputs stay constant while `busy` is high, that `npts` is at least 1, and that `abort` is a single-cycle pulse. The stimulus sets every configuration field before raising the trigger and holds it until the sequence has ended. It raises the abort only for one cycle, just after observing a chosen strobe. Abort cases use intervals of at least two ticks, so that the strobe count after a stop is unambiguous. Sparse-tick runs check spacing only, because the phase of the tick relative to the trigger is free.

// File: rtl/wave_seq.sv
module wave_seq #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              trig_in,
  input  logic              retrig_en,
  input  logic              abort,
  input  logic [1:0]        stop_mode,
  input  logic [CNT_W-1:0]  upd_ivl,
  input  logic [ADDR_W:0]   npts,
  input  logic [CNT_W-1:0]  iter_cnt,
  input  logic [CNT_W-1:0]  start_dly,
  input  logic [CNT_W-1:0]  gap_dly,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              rd_en,
  output logic              dac_upd,
  output logic              zero_clamp,
  output logic              busy
);

  typedef enum logic [2:0] {S_IDLE, S_SDLY, S_PLAY, S_GAP, S_DONE} st_t;

  st_t             st;
  logic            trig_q;
  logic [CNT_W-1:0] dcnt, icnt, itn;
  logic [ADDR_W:0] pt;
  logic            pend, pend_ii;

  logic trig_rise, abort_imm, abort_soft, soft_ii, soft_iii;
  logic last_pt, last_it, iter_stop, gap_stop;
  logic [CNT_W-1:0] ivl_m1;

  assign trig_rise  = trig_in & ~trig_q;
  assign abort_imm  = abort && (stop_mode < 2'd2);
  assign abort_soft = abort && (stop_mode >= 2'd2);
  assign soft_ii    = (pend && pend_ii)  || (abort_soft && stop_mode == 2'd2);
  assign soft_iii   = (pend && !pend_ii) || (abort_soft && stop_mode == 2'd3);
  assign ivl_m1     = (upd_ivl == '0) ? '0 : upd_ivl - 1'b1;
  assign rd_en      = (st == S_PLAY) && tick && (icnt == '0);
  assign last_pt    = (pt == npts - 1'b1);
  assign last_it    = (iter_cnt != '0) && ((itn + 1'b1) == iter_cnt);
  assign gap_stop   = soft_ii || (soft_iii && iter_cnt == '0);
  assign iter_stop  = last_it || gap_stop;
  assign rd_addr    = pt[ADDR_W-1:0];
  assign busy       = (st != S_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st         <= S_IDLE;
      trig_q     <= 1'b0;
      dcnt       <= '0;
      icnt       <= '0;
      itn        <= '0;
      pt         <= '0;
      pend       <= 1'b0;
      pend_ii    <= 1'b0;
      zero_clamp <= 1'b0;
      dac_upd    <= 1'b0;
    end else begin
      trig_q  <= trig_in;
      dac_upd <= rd_en;
      if (abort_imm) begin
        st         <= S_IDLE;
        zero_clamp <= 1'b1;
        pend       <= 1'b0;
        pt         <= '0;
      end else begin
        unique case (st)
          S_IDLE: begin
            if (trig_rise) begin
              st         <= S_SDLY;
              dcnt       <= '0;
              itn        <= '0;
              pt         <= '0;
              pend       <= 1'b0;
              zero_clamp <= 1'b0;
            end
          end
          S_SDLY: begin
            if (abort_soft) begin
              st <= S_DONE;
            end else if (tick) begin
              if (dcnt == start_dly) begin
                st   <= S_PLAY;
                icnt <= '0;
              end else begin
                dcnt <= dcnt + 1'b1;
              end
            end
          end
          S_PLAY: begin
            if (abort_soft) begin
              pend    <= 1'b1;
              pend_ii <= (stop_mode == 2'd2);
            end
            if (rd_en) begin
              icnt <= ivl_m1;
              if (last_pt) begin
                pt   <= '0;
                itn  <= itn + 1'b1;
                dcnt <= '0;
                st   <= iter_stop ? S_DONE : S_GAP;
              end else begin
                pt <= pt + 1'b1;
              end
            end else if (tick && icnt != '0) begin
              icnt <= icnt - 1'b1;
            end
          end
          S_GAP: begin
            if (gap_stop) begin
              st <= S_DONE;
            end else begin
              if (abort_soft) begin
                pend    <= 1'b1;
                pend_ii <= 1'b0;
              end
              if (tick) begin
                if (dcnt == gap_dly) begin
                  st   <= S_PLAY;
                  icnt <= '0;
                end else begin
                  dcnt <= dcnt + 1'b1;
                end
              end
            end
          end
          S_DONE: begin
            if (retrig_en || abort_soft) begin
              st   <= S_IDLE;
              pend <= 1'b0;
            end
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/wave_seq_chk.sv
module wave_seq_chk #(
  parameter int ADDR_W = 11,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick,
  input logic              abort,
  input logic [1:0]        stop_mode,
  input logic [ADDR_W:0]   npts,
  input logic [ADDR_W-1:0] rd_addr,
  input logic              rd_en,
  input logic              dac_upd,
  input logic              zero_clamp,
  input logic              busy
);

  p_strobe_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (tick && busy));

  p_dac_lag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> dac_upd);

  p_dac_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    dac_upd |-> $past(rd_en));

  p_addr_lim_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> ({1'b0, rd_addr} < npts));

  p_abort_i_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (abort && stop_mode < 2'd2) |=> (!busy && zero_clamp));

  p_clamp_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    zero_clamp |-> !rd_en);

endmodule

bind wave_seq wave_seq_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .abort(abort), .stop_mode(stop_mode),
  .npts(npts), .rd_addr(rd_addr), .rd_en(rd_en), .dac_upd(dac_upd),
  .zero_clamp(zero_clamp), .busy(busy));

// File: tb/wave_seq_bench.sv
module wave_seq_bench;
  localparam int AW = 11;
  localparam int CW = 16;

  typedef struct packed {
    int d; int ui; int n; int it; int g; int tdiv; int abt; int mode; int xt;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{0, 1, 4, 1, 0, 1, -1, 0, -1},
    '{3, 2, 5, 2, 1, 1, -1, 0, -1},
    '{1, 3, 3, 3, 4, 1, -1, 0, -1},
    '{2, 0, 6, 1, 0, 1, -1, 0, -1},
    '{1, 2, 4, 2, 2, 3, -1, 0, -1},
    '{0, 2, 4, 0, 1, 1,  5, 1, -1},
    '{1, 2, 4, 0, 1, 1,  5, 2, -1},
    '{1, 2, 4, 3, 1, 1,  1, 3, -1},
    '{0, 2, 3, 0, 2, 1,  4, 3, -1},
    '{0, 2, 4, 3, 1, 1,  1, 2, -1},
    '{2, 1, 1, 3, 0, 1, -1, 0, -1},
    '{1, 2, 4, 2, 1, 1, -1, 0,  8}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, trig_in = 1'b0, retrig_en = 1'b1, abort = 1'b0;
  logic [1:0] stop_mode = 2'd0;
  logic [CW-1:0] upd_ivl = '0, iter_cnt = '0, start_dly = '0, gap_dly = '0;
  logic [AW:0] npts = '0;
  logic [AW-1:0] rd_addr;
  logic rd_en, dac_upd, zero_clamp, busy;

  int nchk = 0, nfail = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  wave_seq #(.ADDR_W(AW), .CNT_W(CW)) u_wave_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .trig_in(trig_in), .retrig_en(retrig_en),
    .abort(abort), .stop_mode(stop_mode), .upd_ivl(upd_ivl), .npts(npts),
    .iter_cnt(iter_cnt), .start_dly(start_dly), .gap_dly(gap_dly),
    .rd_addr(rd_addr), .rd_en(rd_en), .dac_upd(dac_upd),
    .zero_clamp(zero_clamp), .busy(busy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(input logic tk, input logic tg);
    @(negedge clk);
    abort   = 1'b0;
    tick    = tk;
    trig_in = tg;
    #1;
  endtask

  task automatic run_vec(input vec_t v);
    int uie, per, expn, k, prevt, last, tab, tfall, tc;
    logic prev_rd;
    string cl;
    uie = (v.ui == 0) ? 1 : v.ui;
    per = (v.n - 1) * uie + v.g + 2;
    if (v.abt < 0) expn = v.n * v.it;
    else if (v.mode < 2) expn = v.abt + 1;
    else if (v.mode == 3 && v.it != 0) expn = v.n * v.it;
    else expn = (v.abt / v.n + 1) * v.n;
    cl = (v.xt >= 0) ? "R8" : (v.abt < 0) ? "R6" : (v.mode < 2) ? "R10" :
         (v.mode == 2) ? "R11" : "R12";
    k = 0; prevt = -1; last = -1; tab = -1; tfall = -1; tc = 0; prev_rd = 1'b0;
    upd_ivl = CW'(v.ui); npts = (AW+1)'(v.n); iter_cnt = CW'(v.it);
    start_dly = CW'(v.d); gap_dly = CW'(v.g);
    for (int t = 0; t < 3000; t++) begin
      step((tc % v.tdiv) == 0, (t == 0) || (t == v.xt));
      tc++;
      if (prev_rd || dac_upd) chk(dac_upd == prev_rd, "R5", int'(dac_upd), int'(prev_rd));
      prev_rd = rd_en;
      if (rd_en) begin
        chk(rd_addr == AW'(k % v.n), "R4", int'(rd_addr), k % v.n);
        if (v.tdiv == 1)
          chk(t == v.d + 2 + (k / v.n) * per + (k % v.n) * uie,
              (k == 0) ? "R2" : ((k % v.n) == 0) ? "R7" : "R3",
              t, v.d + 2 + (k / v.n) * per + (k % v.n) * uie);
        else if ((k % v.n) != 0)
          chk(t - prevt == uie * v.tdiv, "R3", t - prevt, uie * v.tdiv);
        if (k == v.abt) begin
          abort = 1'b1;
          stop_mode = 2'(v.mode);
          tab = t;
        end
        prevt = t; last = t; k++;
      end
      if (t > 1 && !busy) begin
        tfall = t;
        break;
      end
    end
    chk(k == expn, cl, k, expn);
    if (v.abt >= 0 && v.mode < 2) begin
      chk(tfall == tab + 1, "R10", tfall, tab + 1);
      chk(zero_clamp == 1'b1, "R10", int'(zero_clamp), 1);
    end else begin
      chk(tfall == last + 2, "R9", tfall, last + 2);
    end
    repeat (4) step(1'b1, 1'b0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nfail++;
      $display("FAIL watchdog: got %0d expected %0d", 1, 0);
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    chk(busy == 1'b0, "R1", int'(busy), 0);
    chk(rd_en == 1'b0 && dac_upd == 1'b0, "R1", int'(rd_en | dac_upd), 0);
    chk(zero_clamp == 1'b0, "R1", int'(zero_clamp), 0);
    chk(rd_addr == '0, "R1", int'(rd_addr), 0);
    rst_n = 1'b1;
    repeat (2) step(1'b1, 1'b0);

    foreach (VECS[i]) run_vec(VECS[i]);

    // R9: single-shot hold with re-trigger disabled
    retrig_en = 1'b0;
    upd_ivl = CW'(1); npts = (AW+1)'(2); iter_cnt = CW'(1); start_dly = '0; gap_dly = '0;
    cnt = 0;
    for (int t = 0; t < 20; t++) begin
      step(1'b1, t == 0);
      if (rd_en) cnt++;
    end
    chk(cnt == 2, "R6", cnt, 2);
    chk(busy == 1'b1, "R9", int'(busy), 1);
    cnt = 0;
    for (int t = 0; t < 20; t++) begin
      step(1'b1, t == 0);
      if (rd_en) cnt++;
    end
    chk(cnt == 0, "R9", cnt, 0);
    step(1'b1, 1'b0);
    abort = 1'b1; stop_mode = 2'd2;
    step(1'b1, 1'b0);
    chk(busy == 1'b0, "R9", int'(busy), 0);
    retrig_en = 1'b1;

    // R10: stop code 0 also clamps; clamp clears on the next start
    upd_ivl = CW'(2); npts = (AW+1)'(4); iter_cnt = '0;
    for (int t = 0; t < 10; t++) step(1'b1, t == 0);
    abort = 1'b1; stop_mode = 2'd0;
    step(1'b1, 1'b0);
    chk(busy == 1'b0 && zero_clamp == 1'b1, "R10", int'({busy, zero_clamp}), 1);
    cnt = 0;
    for (int t = 0; t < 10; t++) begin
      step(1'b1, 1'b0);
      if (rd_en) cnt++;
    end
    chk(cnt == 0, "R10", cnt, 0);
    step(1'b1, 1'b1);
    step(1'b1, 1'b0);
    chk(zero_clamp == 1'b0 && busy == 1'b1, "R10", int'({busy, zero_clamp}), 2);
    abort = 1'b1; stop_mode = 2'd1;
    step(1'b1, 1'b0);
    chk(busy == 1'b0, "R10", int'(busy), 0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule